// File: doc/BRIEF.md
# Serial Converter Frame Reader

This block runs in the system clock domain and pulls samples out of a serial analog-to-digital converter. The converter starts a conversion when chip select falls. It puts its first bit on the data line at once, then moves to the next bit on every falling edge of the serial clock. The reader drives chip select and a serial clock divided down from the system clock. It runs a 16-clock or a 14-clock frame, reads the data line on either serial clock edge, removes the framing zeros and passes the result on through a valid/ready port.

A frame starts from a one-cycle start request, which is remembered if it arrives while a frame is running, or continuously while free-run is enabled. Every frame runs to its full length, because raising chip select early would abort the conversion. After each frame, chip select stays high for a programmable quiet interval. No frame starts while a sample is waiting to be accepted. The two framing bits that must read zero are checked, and a frame error flag travels with the sample.

Top module: `sadc_frame_reader`

## Requirements
- R1: Under reset, and after it, cs_n is 1, sclk is 1 and smp_valid is 0.
- R2: sclk stays high whenever cs_n is high; it toggles only inside a frame.
- R3: A frame has exactly 16 sclk falling edges, or 14 when cfg_frame_short is 1. Each sclk half period lasts H = max(cfg_half_div,1) system clocks, and the first falling edge comes H clocks after cs_n falls. cs_n therefore stays low for (2N+1)*H clocks, where N is the number of falling edges.
- R4: Frame bit numbering: bit 0 is on the line when cs_n falls, and bit k is driven after falling edge k. Bits 0 and 1 are leading zeros and the result follows MSB first from bit 2. With cfg_rise_capture 0, bit k is read at falling edge k+1. In 12-bit mode, smp_data[11:0] is bits 2..13.
- R5: With cfg_rise_capture 1, bit k is read at rising edge k. Bit 0 is never read, and the result positions are the same as in R4.
- R6: With cfg_res_narrow 1, the result is 10 bits taken from frame bits 2..11, given on smp_data[9:0] with smp_data[11:10] = 0. This holds in both frame lengths and both capture modes.
- R7: smp_err is 1 when a leading bit that was read is 1. That is bit 0 or bit 1 in falling mode, and bit 1 only in rising mode.
- R8: While smp_valid is 1 and smp_ready is 0, smp_valid, smp_data and smp_err hold, and cs_n does not fall. The sample is consumed on a cycle with both high.
- R9: Between frames cs_n stays high for at least cfg_quiet+2 clocks, and for exactly that many when the output is not back-pressured.
- R10: A start_req pulse gives exactly one frame. A pulse that arrives during a frame is held and gives one further frame. run_en gives frames back to back. With neither, no frame starts.
- R11: cfg_half_div, cfg_frame_short, cfg_rise_capture, cfg_res_narrow and cfg_quiet are sampled when a frame starts. Changing them during a frame has no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_req | input | 1 | One-cycle request for a single frame |
| run_en | input | 1 | Free-run: start frames back to back |
| cfg_res_narrow | input | 1 | 1 = 10-bit result, 0 = 12-bit result |
| cfg_frame_short | input | 1 | 1 = 14-clock frame, 0 = 16-clock frame |
| cfg_rise_capture | input | 1 | 1 = read data on sclk rising edges |
| cfg_half_div | input | DIV_W | System clocks per sclk half period (0 acts as 1) |
| cfg_quiet | input | QUIET_W | Added quiet clocks between frames |
| sdata_in | input | 1 | Serial data from the converter |
| cs_n | output | 1 | Chip select, active low |
| sclk | output | 1 | Serial clock, idles high |
| smp_valid | output | 1 | Sample available |
| smp_ready | input | 1 | Consumer accepts the sample |
| smp_data | output | RES_W | Sample, zero-extended in 10-bit mode |
| smp_err | output | 1 | Leading-zero check failed for this sample |

## Verification
The bound checker covers every cycle. It checks that sclk idles high outside a frame and that each frame has 14 or 16 falling edges. It also checks that a pending sample holds still and blocks the next chip-select assertion, and that the quiet gap is never shorter than its minimum. Other behaviour can only be shown by the bench scenarios, where a converter model drives known words. These are the bit alignment of each capture edge, the exact cs_n low time for each divider, the 10-bit extraction, the edge-dependent error flag, the handling of remembered start requests and the sampling of configuration at frame start.

// File: rtl/sadc_pkg.sv
`timescale 1ns/1ps
// Shared constants and types for the serial converter frame reader.
// Assumes the converter shifts one frame bit per sclk falling edge.
package sadc_pkg;
    localparam int FRAME_BITS = 16;                        // bits in a long frame
    localparam int SHORT_BITS = 14;                        // bits in a short frame
    localparam int LEAD_ZEROS = 2;                         // framing zeros ahead of data
    localparam int FCNT_W     = $clog2(FRAME_BITS + 1);    // falling-edge counter width
    localparam int IDX_W      = $clog2(FRAME_BITS);        // frame bit index width

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_LOW,
        ST_HIGH,
        ST_QUIET
    } seq_state_t;
endpackage

// File: rtl/sadc_phase_timer.sv
`timescale 1ns/1ps
// Down-counter that times one sclk half period.
// Assumes load_val = half period - 1; expired is high in the last cycle.
module sadc_phase_timer #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [DIV_W-1:0] load_val,
    output logic             expired
);
    logic [DIV_W-1:0] cnt_q;

    // Reload on request, otherwise count down and rest at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/sadc_frame_seq.sv
`timescale 1ns/1ps
// Frame sequencer: drives cs_n and sclk, decides when each bit is read,
// holds the configuration for the whole frame and times the quiet gap.
// Assumes out_busy is high while a sample has not been accepted.
module sadc_frame_seq
    import sadc_pkg::*;
#(
    parameter int DIV_W   = 8,
    parameter int QUIET_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_req,
    input  logic               run_en,
    input  logic               out_busy,
    input  logic               cfg_res_narrow,
    input  logic               cfg_frame_short,
    input  logic               cfg_rise_capture,
    input  logic [DIV_W-1:0]   cfg_half_div,
    input  logic [QUIET_W-1:0] cfg_quiet,
    output logic               cs_n,
    output logic               sclk,
    output logic               frame_start,
    output logic               frame_done,
    output logic               cap_en,
    output logic [IDX_W-1:0]   cap_idx,
    output logic               lat_narrow
);
    seq_state_t         st_q;
    logic [FCNT_W-1:0]  fall_cnt_q;
    logic [QUIET_W-1:0] quiet_cnt_q;
    logic [QUIET_W-1:0] quiet_q;
    logic [DIV_W-1:0]   half_q;
    logic               short_q;
    logic               rise_q;
    logic               req_q;
    logic               launch;
    logic               phase_end;
    logic               at_last;
    logic               tmr_load;
    logic [DIV_W-1:0]   tmr_val;
    logic [DIV_W-1:0]   half_in;

    // A divider setting of zero behaves as one.
    assign half_in = (cfg_half_div == '0) ? DIV_W'(1) : cfg_half_div;
    assign launch  = (st_q == ST_IDLE) && (run_en || start_req || req_q) && !out_busy;
    assign at_last = (fall_cnt_q == (short_q ? FCNT_W'(SHORT_BITS) : FCNT_W'(FRAME_BITS)));

    // Reload the half-period timer at frame start and at every phase change.
    always_comb begin
        tmr_load = launch;
        if (phase_end && (st_q == ST_SETUP || st_q == ST_LOW || st_q == ST_HIGH))
            tmr_load = 1'b1;
        tmr_val = launch ? (half_in - DIV_W'(1)) : (half_q - DIV_W'(1));
    end

    sadc_phase_timer #(.DIV_W(DIV_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (phase_end)
    );

    // Remember a start request that could not be served right away.
    always_ff @(posedge clk) begin
        if (!rst_n)
            req_q <= 1'b0;
        else if (launch)
            req_q <= 1'b0;
        else if (start_req)
            req_q <= 1'b1;
    end

    // Main frame state machine with the cs_n and sclk output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q        <= ST_IDLE;
            cs_n        <= 1'b1;
            sclk        <= 1'b1;
            fall_cnt_q  <= '0;
            quiet_cnt_q <= '0;
            quiet_q     <= '0;
            half_q      <= DIV_W'(1);
            short_q     <= 1'b0;
            rise_q      <= 1'b0;
            lat_narrow  <= 1'b0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (launch) begin
                        st_q       <= ST_SETUP;
                        cs_n       <= 1'b0;
                        fall_cnt_q <= '0;
                        half_q     <= half_in;
                        short_q    <= cfg_frame_short;
                        rise_q     <= cfg_rise_capture;
                        lat_narrow <= cfg_res_narrow;
                        quiet_q    <= cfg_quiet;
                    end
                end
                ST_SETUP: begin
                    if (phase_end) begin
                        st_q       <= ST_LOW;
                        sclk       <= 1'b0;
                        fall_cnt_q <= FCNT_W'(1);
                    end
                end
                ST_LOW: begin
                    if (phase_end) begin
                        st_q <= ST_HIGH;
                        sclk <= 1'b1;
                    end
                end
                ST_HIGH: begin
                    if (phase_end) begin
                        if (at_last) begin
                            st_q        <= ST_QUIET;
                            cs_n        <= 1'b1;
                            quiet_cnt_q <= quiet_q;
                        end else begin
                            st_q       <= ST_LOW;
                            sclk       <= 1'b0;
                            fall_cnt_q <= fall_cnt_q + 1'b1;
                        end
                    end
                end
                ST_QUIET: begin
                    if (quiet_cnt_q == '0)
                        st_q <= ST_IDLE;
                    else
                        quiet_cnt_q <= quiet_cnt_q - 1'b1;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // Choose which frame bit to read at this clock edge, if any.
    always_comb begin
        cap_en  = 1'b0;
        cap_idx = '0;
        if (phase_end) begin
            case (st_q)
                ST_SETUP: cap_en = !rise_q;
                ST_LOW: begin
                    if (rise_q && fall_cnt_q < FCNT_W'(FRAME_BITS)) begin
                        cap_en  = 1'b1;
                        cap_idx = fall_cnt_q[IDX_W-1:0];
                    end
                end
                ST_HIGH: begin
                    if (!rise_q && !at_last) begin
                        cap_en  = 1'b1;
                        cap_idx = fall_cnt_q[IDX_W-1:0];
                    end
                end
                default: cap_en = 1'b0;
            endcase
        end
    end

    assign frame_start = launch;
    assign frame_done  = (st_q == ST_HIGH) && phase_end && at_last;
endmodule

// File: rtl/sadc_bit_store.sv
`timescale 1ns/1ps
// Holds the bits read in one frame, pulls out the result and checks the leading zeros.
// Assumes bits that are never read stay at zero after the clear at frame start.
module sadc_bit_store
    import sadc_pkg::*;
#(
    parameter int RES_W    = 12,
    parameter int NARROW_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             cap_en,
    input  logic [IDX_W-1:0] cap_idx,
    input  logic             sdata_in,
    input  logic             narrow,
    output logic [RES_W-1:0] result,
    output logic             lead_err
);
    logic [FRAME_BITS-1:0] bits_q;
    logic [RES_W-1:0]      wide_res;
    logic [NARROW_W-1:0]   nar_res;
    logic [RES_W-1:0]      nar_ext;

    // Clear at frame start, then write each bit read into its slot.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bits_q <= '0;
        else if (clear)
            bits_q <= '0;
        else if (cap_en)
            bits_q[cap_idx] <= sdata_in;
    end

    // MSB first after the leading zeros, for both result widths.
    for (genvar i = 0; i < RES_W; i++) begin : g_wide
        assign wide_res[RES_W-1-i] = bits_q[LEAD_ZEROS+i];
    end
    for (genvar j = 0; j < NARROW_W; j++) begin : g_nar
        assign nar_res[NARROW_W-1-j] = bits_q[LEAD_ZEROS+j];
    end
    if (RES_W > NARROW_W) begin : g_pad
        assign nar_ext = {{(RES_W-NARROW_W){1'b0}}, nar_res};
    end else begin : g_nopad
        assign nar_ext = nar_res;
    end

    assign result = narrow ? nar_ext : wide_res;

    // Leading zeros that were never read stay cleared, so rising mode checks bit 1 only.
    always_comb begin
        lead_err = 1'b0;
        for (int k = 0; k < LEAD_ZEROS; k++)
            lead_err = lead_err | bits_q[k];
    end
endmodule

// File: rtl/sadc_out_stage.sv
`timescale 1ns/1ps
// Valid/ready output register for one sample and its error flag.
// Assumes load only arrives while the stage is empty.
module sadc_out_stage #(
    parameter int RES_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [RES_W-1:0] in_data,
    input  logic             in_err,
    input  logic             ready,
    output logic             valid,
    output logic [RES_W-1:0] data,
    output logic             err
);
    // Take a finished sample, hold it until the consumer accepts it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
            data  <= '0;
            err   <= 1'b0;
        end else if (load) begin
            valid <= 1'b1;
            data  <= in_data;
            err   <= in_err;
        end else if (valid && ready) begin
            valid <= 1'b0;
        end
    end
endmodule

// File: rtl/sadc_frame_reader.sv
`timescale 1ns/1ps
// Top level of the serial converter frame reader. It links the sequencer,
// the bit store and the output stage. Assumes sdata_in is already
// synchronous to clk, with the divider slow enough for the converter.
module sadc_frame_reader #(
    parameter int DIV_W    = 8,
    parameter int QUIET_W  = 8,
    parameter int RES_W    = 12,
    parameter int NARROW_W = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_req,
    input  logic               run_en,
    input  logic               cfg_res_narrow,
    input  logic               cfg_frame_short,
    input  logic               cfg_rise_capture,
    input  logic [DIV_W-1:0]   cfg_half_div,
    input  logic [QUIET_W-1:0] cfg_quiet,
    input  logic               sdata_in,
    output logic               cs_n,
    output logic               sclk,
    output logic               smp_valid,
    input  logic               smp_ready,
    output logic [RES_W-1:0]   smp_data,
    output logic               smp_err
);
    import sadc_pkg::*;

    logic             frame_start;
    logic             frame_done;
    logic             cap_en;
    logic [IDX_W-1:0] cap_idx;
    logic             lat_narrow;
    logic [RES_W-1:0] st_result;
    logic             st_err;

    sadc_frame_seq #(.DIV_W(DIV_W), .QUIET_W(QUIET_W)) u_seq (
        .clk              (clk),
        .rst_n            (rst_n),
        .start_req        (start_req),
        .run_en           (run_en),
        .out_busy         (smp_valid),
        .cfg_res_narrow   (cfg_res_narrow),
        .cfg_frame_short  (cfg_frame_short),
        .cfg_rise_capture (cfg_rise_capture),
        .cfg_half_div     (cfg_half_div),
        .cfg_quiet        (cfg_quiet),
        .cs_n             (cs_n),
        .sclk             (sclk),
        .frame_start      (frame_start),
        .frame_done       (frame_done),
        .cap_en           (cap_en),
        .cap_idx          (cap_idx),
        .lat_narrow       (lat_narrow)
    );

    sadc_bit_store #(.RES_W(RES_W), .NARROW_W(NARROW_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (frame_start),
        .cap_en   (cap_en),
        .cap_idx  (cap_idx),
        .sdata_in (sdata_in),
        .narrow   (lat_narrow),
        .result   (st_result),
        .lead_err (st_err)
    );

    sadc_out_stage #(.RES_W(RES_W)) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (frame_done),
        .in_data (st_result),
        .in_err  (st_err),
        .ready   (smp_ready),
        .valid   (smp_valid),
        .data    (smp_data),
        .err     (smp_err)
    );
endmodule

// File: rtl/sadc_frame_reader_chk.sv
`timescale 1ns/1ps
// Protocol checker for the frame reader, attached with bind.
// Assumes cfg_quiet is only changed while no frame is running.
module sadc_frame_reader_chk #(
    parameter int QUIET_W = 8,
    parameter int RES_W   = 12
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cs_n,
    input logic               sclk,
    input logic               smp_valid,
    input logic               smp_ready,
    input logic [RES_W-1:0]   smp_data,
    input logic               smp_err,
    input logic [QUIET_W-1:0] cfg_quiet
);
    localparam int HI_W = QUIET_W + 2;

    logic            cs_d;
    logic            sclk_d;
    logic [4:0]      fall_cnt;
    logic [HI_W-1:0] hi_cnt;

    // Watch edges, count falling edges per frame and clocks with cs_n high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_d     <= 1'b1;
            sclk_d   <= 1'b1;
            fall_cnt <= '0;
            hi_cnt   <= '1;
        end else begin
            cs_d   <= cs_n;
            sclk_d <= sclk;
            if (!cs_n && cs_d)
                fall_cnt <= '0;
            else if (!cs_n && sclk_d && !sclk)
                fall_cnt <= fall_cnt + 1'b1;
            if (cs_n) begin
                if (hi_cnt != '1)
                    hi_cnt <= hi_cnt + 1'b1;
            end else begin
                hi_cnt <= '0;
            end
        end
    end

    assert_sclk_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> sclk);

    assert_frame_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && !cs_d) |-> (fall_cnt == 5'd14 || fall_cnt == 5'd16));

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && !smp_ready) |=> (smp_valid && $stable(smp_data) && $stable(smp_err)));

    assert_no_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && cs_n) |=> cs_n);

    assert_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && cs_d) |-> (hi_cnt >= HI_W'(cfg_quiet) + HI_W'(2)));
endmodule

bind sadc_frame_reader sadc_frame_reader_chk #(.QUIET_W(QUIET_W), .RES_W(RES_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .sclk      (sclk),
    .smp_valid (smp_valid),
    .smp_ready (smp_ready),
    .smp_data  (smp_data),
    .smp_err   (smp_err),
    .cfg_quiet (cfg_quiet)
);

// File: tb/sadc_frame_reader_tb.sv
`timescale 1ns/1ps
// Directed bench: a converter model drives known frames and each task checks its own results.
module sadc_frame_reader_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_req = 1'b0;
    logic        run_en = 1'b0;
    logic        cfg_res_narrow = 1'b0;
    logic        cfg_frame_short = 1'b0;
    logic        cfg_rise_capture = 1'b0;
    logic [7:0]  cfg_half_div = 8'd1;
    logic [7:0]  cfg_quiet = 8'd0;
    logic        sdata_in = 1'b1;
    logic        cs_n;
    logic        sclk;
    logic        smp_valid;
    logic        smp_ready = 1'b1;
    logic [11:0] smp_data;
    logic        smp_err;

    int n_chk = 0;
    int n_bad = 0;

    // converter model state
    logic [11:0] mdl_word = '0;
    logic        mdl_narrow = 1'b0;
    logic        mdl_b0 = 1'b0;
    logic        mdl_b1 = 1'b0;
    logic [15:0] mdl_frame = '0;
    int          mdl_pos = 0;

    // monitor state
    int mon_frames = 0, mon_low = 0, mon_falls = 0, mon_hi = 0, mon_gap = 0, mon_idle_bad = 0;
    logic prv_cs = 1'b1, prv_sclk = 1'b1;

    always #2.5 clk = ~clk;

    sadc_frame_reader u_dut (
        .clk(clk), .rst_n(rst_n), .start_req(start_req), .run_en(run_en),
        .cfg_res_narrow(cfg_res_narrow), .cfg_frame_short(cfg_frame_short),
        .cfg_rise_capture(cfg_rise_capture), .cfg_half_div(cfg_half_div),
        .cfg_quiet(cfg_quiet), .sdata_in(sdata_in), .cs_n(cs_n), .sclk(sclk),
        .smp_valid(smp_valid), .smp_ready(smp_ready), .smp_data(smp_data), .smp_err(smp_err)
    );

    // Converter model: bit 0 appears when cs_n falls, one new bit per sclk falling edge.
    always @(negedge cs_n) begin
        mdl_frame = '0;
        mdl_frame[0] = mdl_b0;
        mdl_frame[1] = mdl_b1;
        if (mdl_narrow) begin
            for (int i = 0; i < 10; i++) mdl_frame[2+i] = mdl_word[9-i];
        end else begin
            for (int i = 0; i < 12; i++) mdl_frame[2+i] = mdl_word[11-i];
        end
        mdl_pos = 0;
        sdata_in = mdl_frame[0];
    end
    always @(negedge sclk) begin
        if (!cs_n) begin
            mdl_pos = mdl_pos + 1;
            sdata_in = (mdl_pos < 16) ? mdl_frame[mdl_pos] : 1'b0;
        end
    end
    always @(posedge cs_n) sdata_in = 1'b1;

    // Monitor away from the active edge: frame count, low time, falling edges, gap.
    always @(negedge clk) begin
        if (prv_cs && !cs_n) begin
            mon_frames++; mon_low = 1; mon_falls = 0; mon_gap = mon_hi;
        end else if (!cs_n) begin
            mon_low++;
        end
        if (cs_n) mon_hi = prv_cs ? mon_hi + 1 : 1;
        if (!cs_n && prv_sclk && !sclk) mon_falls++;
        if (cs_n && !sclk) mon_idle_bad++;
        prv_cs = cs_n;
        prv_sclk = sclk;
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_start();
        @(negedge clk); start_req = 1'b1;
        @(negedge clk); start_req = 1'b0;
    endtask

    task automatic wait_valid(output bit got);
        got = 0;
        for (int i = 0; i < 4000; i++) begin
            if (smp_valid) begin got = 1; break; end
            @(negedge clk);
        end
    endtask

    // One started frame with given settings, checked for shape, data and error flag.
    task automatic do_frame(input string req, input logic [11:0] w, input bit nar, input bit sh,
                            input bit ri, input int half, input bit b0, input bit b1);
        bit got;
        int n_exp, h_eff, d_exp, e_exp;
        cfg_res_narrow = nar; cfg_frame_short = sh; cfg_rise_capture = ri;
        cfg_half_div = 8'(half);
        mdl_word = w; mdl_narrow = nar; mdl_b0 = b0; mdl_b1 = b1;
        pulse_start();
        wait_valid(got);
        chk(req, "valid seen", int'(got), 1);
        n_exp = sh ? 14 : 16;
        h_eff = (half == 0) ? 1 : half;
        d_exp = nar ? int'(w[9:0]) : int'(w);
        e_exp = int'(b1 | (b0 & !ri));
        chk("R3", "falling edges", mon_falls, n_exp);
        chk("R3", "cs low clocks", mon_low, (2*n_exp+1)*h_eff);
        chk(req, "data", int'(smp_data), d_exp);
        chk("R7", "err flag", int'(smp_err), e_exp);
        cyc(20);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        cyc(4);
        chk("R1", "cs_n in reset", int'(cs_n), 1);
        chk("R1", "sclk in reset", int'(sclk), 1);
        chk("R1", "valid in reset", int'(smp_valid), 0);
        rst_n = 1'b1;
        cyc(3);
        chk("R1", "cs_n after reset", int'(cs_n), 1);
    endtask

    task automatic t_capture_modes();
        do_frame("R4", 12'hA5C, 0, 0, 0, 2, 0, 0);
        do_frame("R4", 12'h3F1, 0, 1, 0, 1, 0, 0);
        do_frame("R5", 12'h9E7, 0, 0, 1, 3, 1, 0);   // bit 0 set but never read
        do_frame("R5", 12'h0C3, 0, 1, 1, 1, 0, 0);
        do_frame("R3", 12'h7A1, 0, 0, 0, 0, 0, 0);   // divider 0 acts as 1
    endtask

    task automatic t_narrow();
        do_frame("R6", 12'hEB7, 1, 0, 0, 2, 0, 0);
        do_frame("R6", 12'hD55, 1, 1, 1, 1, 0, 0);
    endtask

    task automatic t_lead_err();
        do_frame("R7", 12'h123, 0, 0, 0, 1, 1, 0);
        do_frame("R7", 12'h456, 0, 0, 1, 1, 0, 1);
        do_frame("R7", 12'h789, 1, 1, 0, 1, 0, 1);
    endtask

    task automatic t_backpressure();
        bit got;
        logic [11:0] held;
        int f0;
        cfg_res_narrow = 0; cfg_frame_short = 1; cfg_rise_capture = 0; cfg_half_div = 8'd1;
        mdl_word = 12'h5A3; mdl_narrow = 0; mdl_b0 = 0; mdl_b1 = 0;
        smp_ready = 1'b0;
        pulse_start();
        wait_valid(got);
        held = smp_data;
        f0 = mon_frames;
        run_en = 1'b1;
        cyc(60);
        chk("R8", "valid held", int'(smp_valid), 1);
        chk("R8", "data held", int'(smp_data), int'(held));
        chk("R8", "no frame while pending", mon_frames, f0);
        run_en = 1'b0; smp_ready = 1'b1;
        cyc(2);
        chk("R8", "valid cleared after accept", int'(smp_valid), 0);
        cyc(200);
        chk("R10", "no frame without request", mon_frames, f0);
    endtask

    task automatic t_pending_start();
        int f0;
        cfg_frame_short = 1; cfg_half_div = 8'd1; cfg_rise_capture = 0; cfg_res_narrow = 0;
        f0 = mon_frames;
        pulse_start();
        cyc(4);
        pulse_start();                               // lands mid-frame
        cyc(400);
        chk("R10", "held start gives one more frame", mon_frames - f0, 2);
    endtask

    task automatic t_free_run();
        int f0;
        cfg_frame_short = 1; cfg_half_div = 8'd1; cfg_quiet = 8'd5;
        mdl_word = 12'hC0F; mdl_narrow = 0;
        f0 = mon_frames;
        run_en = 1'b1;
        for (int i = 0; i < 3000 && mon_frames < f0 + 3; i++) @(negedge clk);
        chk("R10", "free-run frames", int'(mon_frames >= f0 + 3), 1);
        chk("R9", "quiet gap", mon_gap, 7);
        run_en = 1'b0;
        cyc(100);
        f0 = mon_frames;
        cyc(300);
        chk("R10", "stops when run_en low", mon_frames, f0);
        cfg_quiet = 8'd0;
        cyc(10);
    endtask

    task automatic t_cfg_latch();
        bit got;
        cfg_res_narrow = 0; cfg_frame_short = 0; cfg_rise_capture = 0; cfg_half_div = 8'd2;
        mdl_word = 12'hB2D; mdl_narrow = 0; mdl_b0 = 0; mdl_b1 = 0;
        pulse_start();
        cyc(4);
        cfg_res_narrow = 1; cfg_frame_short = 1; cfg_rise_capture = 1; cfg_half_div = 8'd1;
        wait_valid(got);
        chk("R11", "falling edges", mon_falls, 16);
        chk("R11", "cs low clocks", mon_low, 66);
        chk("R11", "data", int'(smp_data), 12'hB2D);
        cyc(20);
    endtask

    initial begin
        t_reset();
        t_capture_modes();
        t_narrow();
        t_lead_err();
        t_backpressure();
        t_pending_start();
        t_free_run();
        t_cfg_latch();
        chk("R2", "sclk low outside frame", mon_idle_bad, 0);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 5.0);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule